// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt Modes

This block watches a running calendar time and raises an alarm when that time matches a set of programmed fields. There are six fields: seconds, minutes, hours, day of month, month and weekday. Each field has an enable flag in its most significant bit. Only the enabled fields have to match. Enabling only seconds gives one alarm per minute. Enabling the month as well limits the alarm to one window per year.

The match is evaluated only on the one-cycle 1 Hz strobe, so a time that stays equal for a whole second fires once. A fire sets a sticky status flag and drives an active-low interrupt line. In level mode the line stays low for as long as the status flag is set. In pulse mode each fire drives the line low for a fixed number of clock cycles, which is sized for 250 ms.

Software can clear the status flag by writing 0 to it. With auto-clear enabled, reading the status register also clears it. The alarm is suppressed while the interrupt pin is lent to frequency output. It is also suppressed in battery-backup operation unless a control bit allows it there. The time counter that produces the time vector lives outside this block.

Top module: `cal_alarm`

## Requirements
- R1: Register map (3-bit address, 8-bit data): addresses 0..5 hold the alarm fields for seconds, minutes, hours, date, month and weekday. Bit 7 of each field is its enable and bits 6:0 are its value. Address 6 is control, with bit0 pulse mode, bit1 auto-clear, bit2 frequency-output select and bit3 run-in-battery. Address 7 is status, with the alarm flag in bit0. Every written register reads back its value.
- R2: A fire happens only in a cycle where tick_i is high. It requires that at least one field is enabled and that every enabled field's bits 6:0 equal bits 6:0 of the matching byte of time_i. Byte k of time_i is field k. Disabled fields are ignored.
- R3: A fire sets the status flag (alm_o) at the clock edge where tick_i is sampled.
- R4: In level mode (control bit0 = 0), irq_no_o is low exactly while the status flag is set. The flag changes only on a fire or a clear.
- R5: In pulse mode, irq_no_o goes low right after the firing edge and stays low for exactly PULSE_CYCLES clock cycles. A new fire reloads the count.
- R6: Writing status with bit0 = 0 clears the flag. Writing status with bit0 = 1 has no effect.
- R7: When auto-clear is set, reading status returns the flag's current value and then clears it. When auto-clear is not set, reading status leaves the flag unchanged.
- R8: While frequency-output select is set, no fire occurs and irq_no_o is held high.
- R9: While bat_i is high and run-in-battery is clear, no fire occurs. When run-in-battery is set, fires occur normally with bat_i high.
- R10: After reset, all registers are 0, alm_o is 0 and irq_no_o is 1.
- R11: If a fire and a clear happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 Hz strobe |
| time_i | input | 48 | Current time, byte k = field k |
| bat_i | input | 1 | Battery-backup operation flag |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| alm_o | output | 1 | Alarm status flag |
| irq_no_o | output | 1 | Interrupt, active low |

## Verification
A wrong status flag appears on alm_o one edge after the tick or strobe that should have changed it. In level mode it also appears on irq_no_o in the same cycle. A wrong pulse counter shows up as a low interrupt window that is too long or too short, and it is visible within PULSE_CYCLES cycles of a fire. Wrong field gating, wrong suppression or a wrong clear priority produces an alarm that fires when it should not, or misses one it should make. The per-cycle reference model flags that on the next clock.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned ADDR_W     = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd7;

  typedef struct packed {
    logic bat_run;
    logic freq_sel;
    logic auto_clr;
    logic pulse_mode;
  } ctrl_t;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic                          re_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [FIELD_W-1:0]            wdata_i,
  input  logic                          alm_i,
  output logic [NUM_FIELDS*FIELD_W-1:0] fields_o,
  output ctrl_t                         ctrl_o,
  output logic                          st_clr_o,
  output logic [FIELD_W-1:0]            rdata_o
);
  logic [FIELD_W-1:0] field_q [NUM_FIELDS];
  ctrl_t ctrl_q;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 field_q[k] <= '0;
      else if (we_i && addr_i == ADDR_W'(k))       field_q[k] <= wdata_i;
    end
    assign fields_o[k*FIELD_W +: FIELD_W] = field_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ctrl_q <= '0;
    else if (we_i && addr_i == ADDR_CTRL)   ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
  end

  assign ctrl_o = ctrl_q;

  // status write of 0, or status read under auto-clear
  assign st_clr_o = (we_i && addr_i == ADDR_STAT && !wdata_i[0]) ||
                    (re_i && addr_i == ADDR_STAT && ctrl_q.auto_clr);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_STAT)      rdata_o[0] = alm_i;
    else if (addr_i == ADDR_CTRL) rdata_o[$bits(ctrl_t)-1:0] = ctrl_q;
    else if (int'(addr_i) < NUM_FIELDS) rdata_o = field_q[addr_i];
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic [NUM_FIELDS*FIELD_W-1:0] fields_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_i,
  output logic                          match_o
);
  localparam int unsigned VAL_W = FIELD_W - 1;

  logic [NUM_FIELDS-1:0] en, ok;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_cmp
    assign en[k] = fields_i[k*FIELD_W + VAL_W];
    assign ok[k] = !en[k] ||
                   (fields_i[k*FIELD_W +: VAL_W] == time_i[k*FIELD_W +: VAL_W]);
  end

  assign match_o = (|en) && (&ok);
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq #(
  parameter int unsigned PULSE_CYCLES = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic st_clr_i,
  input  logic pulse_mode_i,
  input  logic freq_sel_i,
  output logic alm_o,
  output logic irq_no_o
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

  logic          alm_q;
  logic [CW-1:0] cnt_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       alm_q <= 1'b0;
    else if (fire_i)   alm_q <= 1'b1;
    else if (st_clr_i) alm_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (fire_i && pulse_mode_i)  cnt_q <= CW'(PULSE_CYCLES);
    else if (cnt_q != '0)             cnt_q <= cnt_q - 1'b1;
  end

  assign alm_o    = alm_q;
  assign irq_no_o = freq_sel_i ? 1'b1 : (pulse_mode_i ? (cnt_q == '0) : !alm_q);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_alarm_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 8192
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_i,
  input  logic                          bat_i,
  input  logic                          we_i,
  input  logic                          re_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [FIELD_W-1:0]            wdata_i,
  output logic [FIELD_W-1:0]            rdata_o,
  output logic                          alm_o,
  output logic                          irq_no_o
);
  logic [NUM_FIELDS*FIELD_W-1:0] fields;
  ctrl_t ctrl;
  logic  st_clr, match, fire, suppress;

  cal_alarm_regs u_regs (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i,
    .alm_i(alm_o), .fields_o(fields), .ctrl_o(ctrl),
    .st_clr_o(st_clr), .rdata_o
  );

  cal_alarm_match u_match (
    .fields_i(fields), .time_i, .match_o(match)
  );

  assign suppress = ctrl.freq_sel || (bat_i && !ctrl.bat_run);
  assign fire     = tick_i && match && !suppress;

  cal_alarm_irq #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
    .clk_i, .rst_ni, .fire_i(fire), .st_clr_i(st_clr),
    .pulse_mode_i(ctrl.pulse_mode), .freq_sel_i(ctrl.freq_sel),
    .alm_o, .irq_no_o
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic alm_o,
  input logic irq_no_o,
  input logic freq_sel,
  input logic st_clr
);
  // R3
  alm_rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_o) |-> $past(tick_i));
  // R8
  freq_irq_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_sel |-> irq_no_o);
  // R8
  freq_no_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_o) |-> !$past(freq_sel));
  // R6
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_clr && !tick_i) |=> !alm_o);
  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !st_clr) |=> $stable(alm_o));
endmodule

bind cal_alarm cal_alarm_chk u_chk (
  .clk_i, .rst_ni, .tick_i, .alm_o, .irq_no_o,
  .freq_sel(ctrl.freq_sel), .st_clr(st_clr)
);

// File: tb/tb_cal_alarm.sv
module tb_cal_alarm;
  localparam int CLK_PERIOD = 10;
  localparam int P = 5;

  logic clk = 0, rst_n = 0;
  logic tick = 0, bat = 0, we = 0, re = 0;
  logic [47:0] tv = '0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic alm, irq_n;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  cal_alarm #(.PULSE_CYCLES(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(tv), .bat_i(bat),
    .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .alm_o(alm), .irq_no_o(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int mreg [8];
  bit m_alm;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mreg[i]) mreg[i] = 0;
      m_alm = 0; m_cnt = 0;
    end else begin
      bit any, all, hit, clr;
      any = 0; all = 1;
      for (int k = 0; k < 6; k++) begin
        if (mreg[k][7]) begin
          any = 1;
          if ((mreg[k] & 8'h7f) != (tv[k*8 +: 8] & 8'h7f)) all = 0;
        end
      end
      hit = tick && any && all && !mreg[6][2] && !(bat && !mreg[6][3]);
      clr = (we && addr == 7 && !wdata[0]) || (re && addr == 7 && mreg[6][1]);
      if (hit && mreg[6][0]) m_cnt = P;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (hit) m_alm = 1;
      else if (clr) m_alm = 0;
      if (we && addr != 7) mreg[addr] = (addr == 6) ? (wdata & 8'h0f) : wdata;
    end
  end

  function automatic bit exp_irq();
    if (mreg[6][2]) return 1;
    if (mreg[6][0]) return !(m_cnt > 0);
    return !m_alm;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    n_tests++;
    if (alm !== m_alm || irq_n !== exp_irq()) begin
      n_fail++;
      $display("FAIL R4 R5 per-cycle: alm=%0b irq_n=%0b expected alm=%0b irq_n=%0b",
               alm, irq_n, m_alm, exp_irq());
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [47:0] mk(int s, int m, int h, int d, int mo, int w);
    return {8'(w), 8'(mo), 8'(d), 8'(h), 8'(m), 8'(s)};
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); re = 1; addr = 3'(a); #1 v = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic tk(logic [47:0] t);
    @(negedge clk); tick = 1; tv = t;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    chk(alm == 0, "R10 alm", alm, 0);
    chk(irq_n == 1, "R10 irq", irq_n, 1);
    rd(0, v); chk(v == 0, "R10 reg0", v, 0);

    // R1 readback, R2 single field, R3, R4
    wr(0, 8'h80 | 30);
    wr(1, 5);
    rd(0, v); chk(v == 8'h9e, "R1 readback", v, 8'h9e);
    rd(1, v); chk(v == 5, "R1 readback min", v, 5);
    tk(mk(29, 7, 0, 0, 0, 0));
    chk(alm == 0, "R2 no match", alm, 0);
    tk(mk(30, 7, 0, 0, 0, 0));
    chk(alm == 1, "R3 set / R1 disabled field ignored", alm, 1);
    chk(irq_n == 0, "R4 irq low", irq_n, 0);
    // R2: match held but no tick
    @(negedge clk); tv = mk(30, 7, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rd(7, v); chk(v == 1, "R7 read no auto", v, 1);
    chk(alm == 1, "R7 no auto-clear", alm, 1);
    wr(7, 1); chk(alm == 1, "R6 write 1 no effect", alm, 1);
    wr(7, 0); chk(alm == 0, "R6 clear", alm, 0);
    chk(irq_n == 1, "R4 irq released", irq_n, 1);

    // R2 enabled minute must match
    wr(1, 8'h85);
    tk(mk(30, 7, 0, 0, 0, 0)); chk(alm == 0, "R2 min mismatch", alm, 0);
    tk(mk(30, 5, 0, 0, 0, 0)); chk(alm == 1, "R2 min match", alm, 1);
    wr(7, 0);

    // R5 pulse mode
    wr(6, 1);
    tk(mk(30, 5, 0, 0, 0, 0));
    chk(alm == 1, "R5 status set", alm, 1);
    n = 0;
    while (!irq_n && n < 50) begin n++; @(negedge clk); end
    chk(n == P, "R5 pulse width", n, P);
    chk(alm == 1, "R5 status kept", alm, 1);
    wr(7, 0);

    // R7 auto-clear
    wr(6, 2);
    tk(mk(30, 5, 0, 0, 0, 0));
    rd(7, v); chk(v == 1, "R7 read value", v, 1);
    chk(alm == 0, "R7 auto cleared", alm, 0);

    // R8 frequency select
    wr(6, 0);
    tk(mk(30, 5, 0, 0, 0, 0)); chk(irq_n == 0, "R4 level low", irq_n, 0);
    wr(6, 4); chk(irq_n == 1, "R8 irq held high", irq_n, 1);
    wr(7, 0);
    tk(mk(30, 5, 0, 0, 0, 0)); chk(alm == 0, "R8 no fire", alm, 0);

    // R9 battery
    wr(6, 0); bat = 1;
    tk(mk(30, 5, 0, 0, 0, 0)); chk(alm == 0, "R9 suppressed", alm, 0);
    wr(6, 8);
    tk(mk(30, 5, 0, 0, 0, 0)); chk(alm == 1, "R9 run in battery", alm, 1);
    bat = 0;

    // R11 set beats clear
    @(negedge clk); tick = 1; tv = mk(30, 5, 0, 0, 0, 0); we = 1; addr = 7; wdata = 0;
    @(negedge clk); tick = 0; we = 0;
    chk(alm == 1, "R11 set wins", alm, 1);
    wr(7, 0);

    // R2 all fields
    wr(0, 8'h80 | 10); wr(1, 8'h80 | 20); wr(2, 8'h80 | 7);
    wr(3, 8'h80 | 15); wr(4, 8'h80 | 3); wr(5, 8'h80 | 2);
    tk(mk(10, 20, 7, 15, 3, 3)); chk(alm == 0, "R2 weekday mismatch", alm, 0);
    tk(mk(10, 20, 7, 15, 3, 2)); chk(alm == 1, "R2 full match", alm, 1);
    wr(7, 0);

    // R2 no field enabled
    for (int k = 0; k < 6; k++) wr(k, 0);
    tk(mk(0, 0, 0, 0, 0, 0)); chk(alm == 0, "R2 none enabled", alm, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule